// File: doc/BRIEF.md
# Calendar Clock Update Engine

This block keeps the time and date of a real-time clock: seconds, minutes, hours, day of week, day of month, month, year and a century byte, plus three alarm bytes that are only stored. Each one-second tick from an external divider starts an update. The engine first raises an update-in-progress warning for a fixed number of clock cycles. It then advances every counter in one cycle and pulses an update-ended strobe for the interrupt logic. Software reads and writes the bytes through a single index-addressed port.

The values can be held in BCD or in plain binary, and the hours in 24-hour or 12-hour form with a PM bit. The year wraps into a century reload. An optional daylight-saving rule skips forward one hour in spring and falls back once in autumn. A hold input freezes all updates so that software can load a consistent time.

The FSM has three states. IDLE waits for a tick. WARN raises the warning while a cycle counter runs. UPDATE writes the advanced values for one cycle. Its transitions are: IDLE to WARN on a tick with hold low; WARN to UPDATE when the counter reaches its last value; WARN back to IDLE when hold rises; UPDATE back to IDLE always.

Top module: `rtc_update_engine`

## Requirements
- R1: After reset, seconds, minutes, hours and year read 0x00, day of week, day of month and month read 0x01, century reads 0x20, and `uip` and `upd_done` are low.
- R2: Index 0 is seconds, 1 alarm seconds, 2 minutes, 3 alarm minutes, 4 hours, 5 alarm hours, 6 day of week, 7 day of month, 8 month, 9 year, and 0x32 century. A write stores the byte at that index. Any other index reads 0x00 and ignores writes.
- R3: A tick sampled with hold low raises `uip` for exactly UIP_CYCLES cycles, starting the next cycle. Then `upd_done` is high for one cycle with `uip` low. The advanced values are readable from the cycle after that.
- R4: While `set_hold` is high, `uip` and `upd_done` stay low and no counter changes. A rise of hold during the warning cancels that update.
- R5: With `mode_bin`=0, every time and date byte is two BCD digits. Seconds and minutes wrap from 59 to 00 and carry; 24-hour hours wrap from 23 to 00 and carry into the date.
- R6: With `mode_bin`=1, the same counting is done on plain binary byte values.
- R7: With `mode_24h`=0, hours hold 1 to 12 in bits 6:0 and bit 7 = 1 means PM. 11:59:59 AM becomes 12:00:00 PM, 12:59:59 becomes 1:00:00 in the same half, and 11:59:59 PM becomes 12:00:00 AM of the next day.
- R8: The day of month wraps after the month's length (30 or 31 days; February 29 days when the two-digit year is a multiple of 4, else 28). Day of week counts 1 to 7 (1 = Sunday) and wraps 7 to 1.
- R9: When the year wraps from 99 to 00, century bits 6:0 load 0x20 and bit 7 keeps its written value.
- R10: With `dst_en`=1, on a Sunday in April with day of month 1 to 7, 01:59:59 is followed by 03:00:00.
- R11: With `dst_en`=1, on a Sunday in October with day of month 25 or more, the first 01:59:59 is followed by 01:00:00. A later 01:59:59 that day goes on to 02:00:00. The once-only mark clears at midnight or on a write to the hours byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| sec_tick | input | 1 | One-cycle one-second tick from the divider |
| set_hold | input | 1 | Freezes updates while high |
| mode_bin | input | 1 | 1 = binary values, 0 = BCD |
| mode_24h | input | 1 | 1 = 24-hour hours, 0 = 12-hour with PM bit |
| dst_en | input | 1 | Enables the daylight-saving jumps |
| reg_addr | input | 6 | Register index for read and write |
| reg_wr | input | 1 | Write strobe |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data at `reg_addr` |
| uip | output | 1 | Update-in-progress warning |
| upd_done | output | 1 | One-cycle update-ended pulse |

## Verification
A tick driven before clock edge P0 is due to show `uip` at the samples after P0 through P(UIP_CYCLES-1). `upd_done` is due after edge P(UIP_CYCLES), and the new byte values after edge P(UIP_CYCLES+1). The bench drives on falling edges, samples on the falling edge that follows each of those rising edges, and checks `uip` at every cycle of the window. Reads use the combinational port one time step after the address settles, never across a rising edge. Expected calendar values come from a bench model run on integers, which are then encoded for the selected format.

// File: rtl/rtc_pkg.sv
package rtc_pkg;

    typedef enum logic [1:0] {ST_IDLE, ST_WARN, ST_UPDATE} upd_state_t;

    typedef struct packed {
        logic [7:0] sec;
        logic [7:0] min;
        logic [7:0] hr;
        logic [7:0] dow;
        logic [7:0] dom;
        logic [7:0] mon;
        logic [7:0] yr;
        logic [7:0] cen;
    } cal_t;

    localparam logic [5:0] IDX_SEC  = 6'd0;
    localparam logic [5:0] IDX_ASEC = 6'd1;
    localparam logic [5:0] IDX_MIN  = 6'd2;
    localparam logic [5:0] IDX_AMIN = 6'd3;
    localparam logic [5:0] IDX_HR   = 6'd4;
    localparam logic [5:0] IDX_AHR  = 6'd5;
    localparam logic [5:0] IDX_DOW  = 6'd6;
    localparam logic [5:0] IDX_DOM  = 6'd7;
    localparam logic [5:0] IDX_MON  = 6'd8;
    localparam logic [5:0] IDX_YR   = 6'd9;
    localparam logic [5:0] IDX_CEN  = 6'h32;

    // Byte as stored -> plain number
    function automatic logic [7:0] to_num(input logic [7:0] v, input logic binm);
        return binm ? v : ({4'd0, v[7:4]} * 8'd10 + {4'd0, v[3:0]});
    endfunction

    // Plain number -> byte as stored
    function automatic logic [7:0] from_num(input logic [7:0] v, input logic binm);
        logic [7:0] tens, ones;
        tens = v / 8'd10;
        ones = v % 8'd10;
        return binm ? v : {tens[3:0], ones[3:0]};
    endfunction

    function automatic logic [7:0] month_len(input logic [7:0] mo, input logic [7:0] yr);
        unique case (mo)
            8'd4, 8'd6, 8'd9, 8'd11: return 8'd30;
            8'd2:                    return (yr[1:0] == 2'd0) ? 8'd29 : 8'd28;
            default:                 return 8'd31;
        endcase
    endfunction

endpackage

// File: rtl/rtc_seq.sv
module rtc_seq
    import rtc_pkg::*;
#(
    parameter int UIP_CYCLES = 8
) (
    input  logic clk,
    input  logic rst_n,
    input  logic sec_tick,
    input  logic set_hold,
    output logic uip,
    output logic upd_done
);
    localparam int CW = $clog2(UIP_CYCLES + 1);
    localparam logic [CW-1:0] LAST = CW'(UIP_CYCLES - 1);

    upd_state_t state, state_n;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_IDLE;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= (state == ST_WARN && state_n == ST_WARN) ? cnt + 1'b1 : '0;
        end
    end

    always_comb begin
        state_n = state;
        unique case (state)
            ST_IDLE:   if (sec_tick && !set_hold) state_n = ST_WARN;
            ST_WARN:   if (set_hold) state_n = ST_IDLE;
                       else if (cnt == LAST) state_n = ST_UPDATE;
            ST_UPDATE: state_n = ST_IDLE;
            default:   state_n = ST_IDLE;
        endcase
    end

    always_comb begin
        uip      = (state == ST_WARN)   && !set_hold;
        upd_done = (state == ST_UPDATE) && !set_hold;
    end

endmodule

// File: rtl/rtc_calc.sv
module rtc_calc
    import rtc_pkg::*;
(
    input  cal_t cur,
    input  logic binm,
    input  logic h24,
    input  logic dst_en,
    input  logic fb_done,
    output cal_t nxt,
    output logic fb_take,
    output logic day_roll
);
    logic [7:0] s, m, h, dw, dm, mo, yr, h12, hm, hb;
    logic at_159, spring, yr_roll;

    always_comb begin
        day_roll = 1'b0;
        yr_roll  = 1'b0;
        h12      = to_num({1'b0, cur.hr[6:0]}, binm);
        s  = to_num(cur.sec, binm);
        m  = to_num(cur.min, binm);
        dm = to_num(cur.dom, binm);
        mo = to_num(cur.mon, binm);
        yr = to_num(cur.yr,  binm);
        dw = cur.dow;
        if (h24) h = to_num(cur.hr, binm);
        else     h = ((h12 == 8'd12) ? 8'd0 : h12) + (cur.hr[7] ? 8'd12 : 8'd0);

        at_159  = (h == 8'd1) && (m == 8'd59) && (s == 8'd59) && (dw == 8'd1) && dst_en;
        spring  = at_159 && (mo == 8'd4)  && (dm <= 8'd7);
        fb_take = at_159 && (mo == 8'd10) && (dm >= 8'd25) && !fb_done;

        if (spring) begin
            h = 8'd3; m = 8'd0; s = 8'd0;
        end else if (fb_take) begin
            m = 8'd0; s = 8'd0;
        end else if (s != 8'd59) begin
            s = s + 8'd1;
        end else begin
            s = 8'd0;
            if (m != 8'd59) m = m + 8'd1;
            else begin
                m = 8'd0;
                if (h != 8'd23) h = h + 8'd1;
                else begin
                    h = 8'd0;
                    day_roll = 1'b1;
                    dw = (dw >= 8'd7) ? 8'd1 : dw + 8'd1;
                    if (dm < month_len(mo, yr)) dm = dm + 8'd1;
                    else begin
                        dm = 8'd1;
                        if (mo < 8'd12) mo = mo + 8'd1;
                        else begin
                            mo = 8'd1;
                            if (yr < 8'd99) yr = yr + 8'd1;
                            else begin
                                yr = 8'd0;
                                yr_roll = 1'b1;
                            end
                        end
                    end
                end
            end
        end

        hm = (h >= 8'd12) ? h - 8'd12 : h;
        if (hm == 8'd0) hm = 8'd12;
        hb = from_num(hm, binm);

        nxt.sec = from_num(s, binm);
        nxt.min = from_num(m, binm);
        nxt.hr  = h24 ? from_num(h, binm) : {h >= 8'd12, hb[6:0]};
        nxt.dow = dw;
        nxt.dom = from_num(dm, binm);
        nxt.mon = from_num(mo, binm);
        nxt.yr  = from_num(yr, binm);
        nxt.cen = yr_roll ? {cur.cen[7], 7'h20} : cur.cen;
    end

endmodule

// File: rtl/rtc_update_engine.sv
module rtc_update_engine
    import rtc_pkg::*;
#(
    parameter int UIP_CYCLES = 8,   // set to 244 us worth of block clocks
    parameter int ADDR_W     = 6
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sec_tick,
    input  logic              set_hold,
    input  logic              mode_bin,
    input  logic              mode_24h,
    input  logic              dst_en,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic              reg_wr,
    input  logic [7:0]        reg_wdata,
    output logic [7:0]        reg_rdata,
    output logic              uip,
    output logic              upd_done
);
    cal_t       cal_q, cal_n;
    logic [7:0] al_sec, al_min, al_hr;
    logic       fb_q, fb_take, day_roll;

    rtc_seq #(.UIP_CYCLES(UIP_CYCLES)) i_seq (
        .clk(clk), .rst_n(rst_n), .sec_tick(sec_tick), .set_hold(set_hold),
        .uip(uip), .upd_done(upd_done)
    );

    rtc_calc i_calc (
        .cur(cal_q), .binm(mode_bin), .h24(mode_24h), .dst_en(dst_en),
        .fb_done(fb_q), .nxt(cal_n), .fb_take(fb_take), .day_roll(day_roll)
    );

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cal_q  <= '{sec: 8'h00, min: 8'h00, hr: 8'h00, dow: 8'h01,
                        dom: 8'h01, mon: 8'h01, yr: 8'h00, cen: 8'h20};
            al_sec <= '0;
            al_min <= '0;
            al_hr  <= '0;
            fb_q   <= 1'b0;
        end else begin
            if (upd_done) begin
                cal_q <= cal_n;
                if (fb_take)       fb_q <= 1'b1;
                else if (day_roll) fb_q <= 1'b0;
            end
            if (reg_wr) begin
                unique case (6'(reg_addr))
                    IDX_SEC:  cal_q.sec <= reg_wdata;
                    IDX_ASEC: al_sec    <= reg_wdata;
                    IDX_MIN:  cal_q.min <= reg_wdata;
                    IDX_AMIN: al_min    <= reg_wdata;
                    IDX_HR:   begin cal_q.hr <= reg_wdata; fb_q <= 1'b0; end
                    IDX_AHR:  al_hr     <= reg_wdata;
                    IDX_DOW:  cal_q.dow <= reg_wdata;
                    IDX_DOM:  cal_q.dom <= reg_wdata;
                    IDX_MON:  cal_q.mon <= reg_wdata;
                    IDX_YR:   cal_q.yr  <= reg_wdata;
                    IDX_CEN:  cal_q.cen <= reg_wdata;
                    default:  ;
                endcase
            end
        end
    end

    always_comb begin
        unique case (6'(reg_addr))
            IDX_SEC:  reg_rdata = cal_q.sec;
            IDX_ASEC: reg_rdata = al_sec;
            IDX_MIN:  reg_rdata = cal_q.min;
            IDX_AMIN: reg_rdata = al_min;
            IDX_HR:   reg_rdata = cal_q.hr;
            IDX_AHR:  reg_rdata = al_hr;
            IDX_DOW:  reg_rdata = cal_q.dow;
            IDX_DOM:  reg_rdata = cal_q.dom;
            IDX_MON:  reg_rdata = cal_q.mon;
            IDX_YR:   reg_rdata = cal_q.yr;
            IDX_CEN:  reg_rdata = cal_q.cen;
            default:  reg_rdata = 8'h00;
        endcase
    end

endmodule

// File: rtl/rtc_update_chk.sv
module rtc_update_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       set_hold,
    input logic       uip,
    input logic       upd_done,
    input logic       reg_wr,
    input logic [7:0] sec_q
);
    AST_DONE_SINGLE:  assert property (@(posedge clk) disable iff (!rst_n) upd_done |=> !upd_done);  // R3
    AST_DONE_AFTER_WARN: assert property (@(posedge clk) disable iff (!rst_n) upd_done |-> $past(uip)); // R3
    AST_HOLD_QUIET:   assert property (@(posedge clk) disable iff (!rst_n) set_hold |-> (!uip && !upd_done)); // R4
    AST_SEC_STEADY:   assert property (@(posedge clk) disable iff (!rst_n) (!upd_done && !reg_wr) |=> $stable(sec_q)); // R4
endmodule

bind rtc_update_engine rtc_update_chk i_chk (
    .clk(clk), .rst_n(rst_n), .set_hold(set_hold), .uip(uip),
    .upd_done(upd_done), .reg_wr(reg_wr), .sec_q(cal_q.sec)
);

// File: tb/test_rtc_update_engine.sv
module test_rtc_update_engine;
    localparam int CLK_PERIOD = 10;
    localparam int NUIP = 8;

    logic clk = 0, rst_n = 0, sec_tick = 0, set_hold = 0;
    logic mode_bin = 0, mode_24h = 1, dst_en = 0;
    logic [5:0] reg_addr = 0;
    logic reg_wr = 0;
    logic [7:0] reg_wdata = 0;
    logic [7:0] reg_rdata;
    logic uip, upd_done;

    int total = 0, bad = 0;
    int ts, tm, th, tw, td, tmo, ty;
    logic [7:0] tc;
    bit fbd;

    rtc_update_engine i_rtc_update_engine (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    task automatic chk(input bit ok, input string req, input string what, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
        end
    endtask

    function automatic logic [7:0] enc(input int v);
        return mode_bin ? 8'(v) : 8'(((v / 10) << 4) | (v % 10));
    endfunction

    function automatic logic [7:0] enc_hr(input int h);
        int h12;
        logic [7:0] b;
        if (mode_24h) return enc(h);
        h12 = (h % 12 == 0) ? 12 : h % 12;
        b = enc(h12);
        return {(h >= 12), b[6:0]};
    endfunction

    function automatic int mdays(input int mo, input int yr);
        if (mo == 2) return (yr % 4 == 0) ? 29 : 28;
        if (mo == 4 || mo == 6 || mo == 9 || mo == 11) return 30;
        return 31;
    endfunction

    task automatic model_tick();
        bit at = dst_en && th == 1 && tm == 59 && ts == 59 && tw == 1;
        if (at && tmo == 4 && td <= 7) begin
            th = 3; tm = 0; ts = 0;
        end else if (at && tmo == 10 && td >= 25 && !fbd) begin
            tm = 0; ts = 0; fbd = 1;
        end else begin
            ts++;
            if (ts == 60) begin ts = 0; tm++; end
            if (tm == 60) begin tm = 0; th++; end
            if (th == 24) begin
                th = 0; fbd = 0;
                tw = tw % 7 + 1;
                td++;
                if (td > mdays(tmo, ty)) begin td = 1; tmo++; end
                if (tmo == 13) begin tmo = 1; ty++; end
                if (ty == 100) begin ty = 0; tc = {tc[7], 7'h20}; end
            end
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        reg_wr = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_wr = 0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [7:0] d);
        reg_addr = a;
        #1;
        d = reg_rdata;
    endtask

    task automatic load_all();
        wr(0, enc(ts)); wr(2, enc(tm)); wr(4, enc_hr(th)); wr(6, 8'(tw));
        wr(7, enc(td)); wr(8, enc(tmo)); wr(9, enc(ty)); wr(6'h32, tc);
        fbd = 0;
    endtask

    task automatic check_all(input string req);
        logic [7:0] d;
        rd(0, d); chk(d == enc(ts), req, "seconds", d, enc(ts));
        rd(2, d); chk(d == enc(tm), req, "minutes", d, enc(tm));
        rd(4, d); chk(d == enc_hr(th), req, "hours", d, enc_hr(th));
        rd(6, d); chk(d == 8'(tw), req, "weekday", d, tw);
        rd(7, d); chk(d == enc(td), req, "day", d, enc(td));
        rd(8, d); chk(d == enc(tmo), req, "month", d, enc(tmo));
        rd(9, d); chk(d == enc(ty), req, "year", d, enc(ty));
        rd(6'h32, d); chk(d == tc, req, "century", d, tc);
    endtask

    // Tick plus R3 window checks; model advanced alongside
    task automatic do_tick();
        int hi = 0;
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        for (int k = 0; k < NUIP; k++) begin
            if (uip === 1'b1 && upd_done === 1'b0) hi++;
            @(negedge clk);
        end
        chk(hi == NUIP, "R3", "uip window length", hi, NUIP);
        chk(upd_done === 1'b1 && uip === 1'b0, "R3", "upd_done after window", upd_done, 1);
        @(negedge clk);
        chk(upd_done === 1'b0, "R3", "upd_done single cycle", upd_done, 0);
        model_tick();
    endtask

    task automatic set_time(input int s, m, h, w, d, mo, y, input logic [7:0] c);
        ts = s; tm = m; th = h; tw = w; td = d; tmo = mo; ty = y; tc = c;
        load_all();
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        chk(0, "WD", "watchdog expired", 0, 1);
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        logic [7:0] d;
        int seen;
        void'($urandom(32'd2024));
        #(CLK_PERIOD * 3);
        @(negedge clk);
        // R1 reset state
        rd(0, d); chk(d == 8'h00, "R1", "reset seconds", d, 0);
        rd(4, d); chk(d == 8'h00, "R1", "reset hours", d, 0);
        rd(7, d); chk(d == 8'h01, "R1", "reset day", d, 1);
        rd(8, d); chk(d == 8'h01, "R1", "reset month", d, 1);
        rd(6, d); chk(d == 8'h01, "R1", "reset weekday", d, 1);
        rd(6'h32, d); chk(d == 8'h20, "R1", "reset century", d, 8'h20);
        chk(uip === 1'b0 && upd_done === 1'b0, "R1", "reset status", {uip, upd_done}, 0);
        rst_n = 1;
        @(negedge clk);

        // R2 register map
        wr(1, 8'h11); wr(3, 8'h22); wr(5, 8'h33); wr(6'h20, 8'h5A); wr(6'h0B, 8'hA5);
        rd(1, d); chk(d == 8'h11, "R2", "alarm sec", d, 8'h11);
        rd(3, d); chk(d == 8'h22, "R2", "alarm min", d, 8'h22);
        rd(5, d); chk(d == 8'h33, "R2", "alarm hr", d, 8'h33);
        rd(6'h20, d); chk(d == 8'h00, "R2", "unmapped 0x20", d, 0);
        rd(6'h0B, d); chk(d == 8'h00, "R2", "unmapped 0x0B", d, 0);
        rd(0, d); chk(d == 8'h00, "R2", "unmapped write left seconds", d, 0);

        // R5 R9 BCD full rollover, century bit 7 kept
        mode_bin = 0; mode_24h = 1;
        set_time(59, 59, 23, 7, 31, 12, 99, 8'h99);
        do_tick(); check_all("R5/R9");
        chk(tc == 8'hA0, "R9", "bench century model", tc, 8'hA0);

        // R6 binary mode
        mode_bin = 1;
        set_time(59, 59, 9, 3, 30, 4, 45, 8'h20);
        do_tick(); check_all("R6");

        // R7 12-hour cases
        mode_bin = 0; mode_24h = 0;
        set_time(59, 59, 11, 2, 10, 5, 30, 8'h20); do_tick(); check_all("R7 am-pm");
        set_time(59, 59, 12, 2, 10, 5, 30, 8'h20); do_tick(); check_all("R7 12-1");
        set_time(59, 59, 23, 2, 10, 5, 30, 8'h20); do_tick(); check_all("R7 pm-am");
        rd(4, d); chk(d == 8'h12, "R7", "midnight is 12 AM", d, 8'h12);

        // R8 month lengths, leap year, weekday wrap
        mode_24h = 1;
        set_time(59, 59, 23, 7, 28, 2, 23, 8'h20); do_tick(); check_all("R8 feb common");
        chk(tmo == 3 && tw == 1, "R8", "model mar1 sunday", tmo, 3);
        set_time(59, 59, 23, 4, 28, 2, 24, 8'h20); do_tick(); check_all("R8 feb leap");
        set_time(59, 59, 23, 4, 30, 6, 24, 8'h20); do_tick(); check_all("R8 june");

        // R10 spring forward
        dst_en = 1;
        set_time(59, 59, 1, 1, 3, 4, 22, 8'h20); do_tick(); check_all("R10");
        rd(4, d); chk(d == 8'h03, "R10", "hour after jump", d, 3);

        // R11 fall back once
        set_time(59, 59, 1, 1, 30, 10, 22, 8'h20); do_tick(); check_all("R11 first");
        rd(4, d); chk(d == 8'h01, "R11", "hour repeated", d, 1);
        wr(0, 8'h59); wr(2, 8'h59); ts = 59; tm = 59;
        do_tick(); check_all("R11 second");
        rd(4, d); chk(d == 8'h02, "R11", "no second fallback", d, 2);
        dst_en = 0;

        // R4 hold blocks update
        set_time(10, 20, 5, 2, 6, 7, 22, 8'h20);
        set_hold = 1;
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        seen = 0;
        for (int k = 0; k < NUIP + 3; k++) begin
            if (uip !== 1'b0 || upd_done !== 1'b0) seen++;
            @(negedge clk);
        end
        chk(seen == 0, "R4", "status quiet while held", seen, 0);
        check_all("R4 frozen");
        // R4 hold rising mid-warning cancels
        set_hold = 0;
        @(negedge clk); sec_tick = 1;
        @(negedge clk); sec_tick = 0;
        @(negedge clk); set_hold = 1;
        seen = 0;
        for (int k = 0; k < NUIP + 3; k++) begin
            if (upd_done !== 1'b0) seen++;
            @(negedge clk);
        end
        set_hold = 0;
        chk(seen == 0, "R4", "no done after cancel", seen, 0);
        check_all("R4 cancel");

        // Random times, both encodings and hour formats (R5 R6 R7 R8)
        for (int i = 0; i < 40; i++) begin
            mode_bin = 1'($urandom % 2);
            mode_24h = 1'($urandom % 2);
            ts  = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
            tm  = ($urandom % 3 == 0) ? 59 : int'($urandom % 60);
            th  = ($urandom % 3 == 0) ? 23 : int'($urandom % 24);
            tw  = 1 + int'($urandom % 7);
            tmo = 1 + int'($urandom % 12);
            ty  = ($urandom % 4 == 0) ? 99 : int'($urandom % 100);
            td  = ($urandom % 2 == 0) ? mdays(tmo, ty) : 1 + int'($urandom % 28);
            tc  = {1'($urandom % 2), 7'h19};
            load_all();
            do_tick();
            check_all(mode_bin ? "R6 random" : "R5 random");
        end

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule